// File: doc/BRIEF.md
# Parallel LCD Bus Write Sequencer

This block drives the write side of a character LCD controller's parallel bus from a synchronous host. A requester hands over one byte with a register-select flag and a width flag. The block then moves the register-select line, the read/write line, the enable strobe and the eight data lines through a fixed phase sequence. Every minimum interval on the bus is met in whole clock cycles.

Each nanosecond minimum is a parameter. It is turned into a cycle count by dividing by the clock-period parameter and rounding up. With the default 4 ns clock this gives:

| Interval | Cycles |
|---|---|
| Address setup | 10 |
| Strobe high | 55 |
| Hold after the strobe falls | 3 |
| Rise-to-rise spacing | 125 |

In narrow mode a byte goes out as two nibbles on the upper four data lines. The upper nibble goes first. Each nibble has its own complete strobe cycle. A valid/ready handshake admits the next byte only after the last strobe's hold and spacing time has run out.

Top module: `pbus_write_seq`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `lcd_e`, `lcd_rw`, `lcd_rs` and `lcd_db` are all 0.
- R2: `lcd_rw` is 0 at every cycle; the block only writes.
- R3: `lcd_rs` and `lcd_db` carry the new beat's values for at least ceil(40 ns / clock) cycles before `lcd_e` rises. This is 10 cycles at the default clock.
- R4: Each high level of `lcd_e` lasts at least ceil(max(220, 60) ns / clock) cycles, which is 55 at default. Each low level between two strobes lasts at least ceil(220 ns / clock) cycles.
- R5: Successive rising edges of `lcd_e` are at least ceil(500 ns / clock) cycles apart, which is 125 at default. This holds between the two nibbles of one byte and between separate requests.
- R6: `lcd_rs` and `lcd_db` do not change while `lcd_e` is high. After `lcd_e` falls they stay unchanged for at least ceil(10 ns / clock) cycles, which is 3 at default.
- R7: In wide mode (`req_nibble`=0), a request produces exactly one strobe. During that strobe `lcd_db[7:0]` equals the request byte and `lcd_rs` equals `req_rs`.
- R8: In narrow mode (`req_nibble`=1), a request produces exactly two strobes. The first carries byte bits 7..4 on `lcd_db[7:4]`. The second carries bits 3..0 on `lcd_db[7:4]`. `lcd_db[3:0]` is 0 during both, and `lcd_rs` is the same for both.
- R9: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for exactly 125 cycles per strobe at default, so 125 for wide and 250 for narrow. Request inputs that change while `req_ready` is 0 have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_rs | input | 1 | Register-select value for this write |
| req_data | input | 8 | Byte to write |
| req_nibble | input | 1 | 1: send as two nibbles on the upper lines |
| lcd_rs | output | 1 | Bus register-select line |
| lcd_rw | output | 1 | Bus read/write line, held low |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db | output | 8 | Bus data lines |

## Verification
Take an acceptance edge k as the reference. The new bus values appear right after edge k. The strobe rises after edge k+10 and falls after edge k+65. `req_ready` returns after edge k+125 per strobe.

The bench samples every output on the falling clock edge, half a cycle after each of those registered changes. It counts intervals as the number of falling edges a level was seen. An expected beat is pushed when a request is driven and popped when the strobe falls. The busy length is counted as the falling edges seen with `req_ready` low, and it must match the per-strobe figure exactly.

// File: rtl/pbus_pkg.sv
// Shared types and cycle arithmetic for the parallel LCD write sequencer.
// Assumes all timing arguments are non-negative nanosecond integers.
package pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_GAP
    } phase_t;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Subtraction that floors at zero instead of wrapping.
    function automatic int unsigned usub(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/pbus_timer.sv
// Loadable down-counter that times one bus phase.
// Assumes: load_val = phase length - 1; expired is high in the last cycle of the phase.
module pbus_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Reload on a phase change, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pbus_phase_fsm.sv
// Phase sequencer: idle -> setup -> strobe high -> hold -> gap, once per beat.
// Runs a second beat when the latched transfer is in nibble mode.
// Assumes every phase length parameter is at least 1.
module pbus_phase_fsm
    import pbus_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LEN_SU  = 10,
    parameter int unsigned LEN_HI  = 55,
    parameter int unsigned LEN_HLD = 3,
    parameter int unsigned LEN_GAP = 57
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   nibble_mode,
    output phase_t phase,
    output logic   beat
);
    phase_t           phase_nxt;
    logic             beat_nxt;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    // Next phase and beat from the current phase and the phase timer.
    always_comb begin
        phase_nxt = phase;
        beat_nxt  = beat;
        unique case (phase)
            PH_IDLE:  if (start) begin
                          phase_nxt = PH_SETUP;
                          beat_nxt  = 1'b0;
                      end
            PH_SETUP: if (t_done) phase_nxt = PH_HIGH;
            PH_HIGH:  if (t_done) phase_nxt = PH_HOLD;
            PH_HOLD:  if (t_done) phase_nxt = PH_GAP;
            PH_GAP:   if (t_done) begin
                          if (nibble_mode && !beat) begin
                              phase_nxt = PH_SETUP;
                              beat_nxt  = 1'b1;
                          end else begin
                              phase_nxt = PH_IDLE;
                          end
                      end
            default:  phase_nxt = PH_IDLE;
        endcase
    end

    // Timer reload value for the phase being entered.
    always_comb begin
        t_load = (phase_nxt != phase);
        unique case (phase_nxt)
            PH_SETUP: t_val = CNT_W'(LEN_SU - 1);
            PH_HIGH:  t_val = CNT_W'(LEN_HI - 1);
            PH_HOLD:  t_val = CNT_W'(LEN_HLD - 1);
            PH_GAP:   t_val = CNT_W'(LEN_GAP - 1);
            default:  t_val = '0;
        endcase
    end

    // Phase and beat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            beat  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            beat  <= beat_nxt;
        end
    end

    pbus_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    AST_SECOND_BEAT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> nibble_mode); // R8

endmodule

// File: rtl/pbus_lane_mux.sv
// Routes the latched byte onto the data lines.
// Wide mode: the full byte. Narrow mode: one nibble on the upper lines, selected by
// beat (0 = high nibble), with the lower lines driven to zero.
module pbus_lane_mux #(
    parameter int unsigned BUS_W = 8
) (
    input  logic [BUS_W-1:0] byte_in,
    input  logic             nibble_mode,
    input  logic             beat,
    output logic [BUS_W-1:0] lanes
);
    localparam int unsigned HALF = BUS_W / 2;

    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        if (i >= HALF) begin : g_upper
            // Upper lane: own bit, or the matching low-nibble bit on the second beat.
            assign lanes[i] = (nibble_mode && beat) ? byte_in[i-HALF] : byte_in[i];
        end else begin : g_lower
            // Lower lane: unused in narrow mode.
            assign lanes[i] = nibble_mode ? 1'b0 : byte_in[i];
        end
    end

endmodule

// File: rtl/pbus_write_seq.sv
// Parallel LCD bus write sequencer (top).
// Accepts one byte per valid/ready handshake and produces one or two timed strobes.
// Assumes: synchronous active-low reset, CLK_NS is the clock period in ns,
// and all minimums are given in ns.
module pbus_write_seq
    import pbus_pkg::*;
#(
    parameter int unsigned CLK_NS      = 4,
    parameter int unsigned ADDR_SU_NS  = 40,
    parameter int unsigned ADDR_HLD_NS = 10,
    parameter int unsigned PULSE_NS    = 220,
    parameter int unsigned PERIOD_NS   = 500,
    parameter int unsigned DATA_SU_NS  = 60,
    parameter int unsigned DATA_HLD_NS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [7:0] req_data,
    input  logic       req_nibble,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db
);
    localparam int unsigned BUS_W   = 8;
    localparam int unsigned C_SU    = umax(1, ns_to_cyc(ADDR_SU_NS, CLK_NS));
    localparam int unsigned C_HI    = umax(1, umax(ns_to_cyc(PULSE_NS, CLK_NS),
                                                   ns_to_cyc(DATA_SU_NS, CLK_NS)));
    localparam int unsigned C_HLD   = umax(1, umax(ns_to_cyc(ADDR_HLD_NS, CLK_NS),
                                                   ns_to_cyc(DATA_HLD_NS, CLK_NS)));
    localparam int unsigned C_LO    = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int unsigned C_CYC   = ns_to_cyc(PERIOD_NS, CLK_NS);
    localparam int unsigned C_LOW   = umax(C_LO, usub(C_CYC, C_HI));
    localparam int unsigned C_GAP   = umax(1, usub(C_LOW, C_HLD + C_SU));
    localparam int unsigned C_MAX   = umax(umax(C_SU, C_HI), umax(C_HLD, C_GAP));
    localparam int unsigned CNT_W   = $clog2(C_MAX + 1);

    phase_t           phase;
    logic             beat;
    logic             accept;
    logic             rs_q;
    logic             nib_q;
    logic [BUS_W-1:0] data_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Capture the request on acceptance; the values hold for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q   <= 1'b0;
            nib_q  <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            rs_q   <= req_rs;
            nib_q  <= req_nibble;
            data_q <= req_data;
        end
    end

    pbus_phase_fsm #(
        .CNT_W   (CNT_W),
        .LEN_SU  (C_SU),
        .LEN_HI  (C_HI),
        .LEN_HLD (C_HLD),
        .LEN_GAP (C_GAP)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .nibble_mode (nib_q),
        .phase       (phase),
        .beat        (beat)
    );

    pbus_lane_mux #(.BUS_W(BUS_W)) u_lanes (
        .byte_in     (data_q),
        .nibble_mode (nib_q),
        .beat        (beat),
        .lanes       (lcd_db)
    );

    assign lcd_rs = rs_q;
    assign lcd_rw = 1'b0;
    assign lcd_e  = (phase == PH_HIGH);

    // ---------------- interval monitors for the assertions ----------------
    logic [15:0]      hi_cnt, lo_cnt, bus_age, hi_last;
    logic             seen_fall;
    logic [BUS_W:0]   bus_q;

    // Count strobe high/low run lengths and the age of the current bus value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            bus_age   <= '0;
            hi_last   <= '0;
            seen_fall <= 1'b0;
            bus_q     <= '0;
        end else begin
            hi_cnt <= lcd_e ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt <= lcd_e ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
            if (!lcd_e && hi_cnt != '0) begin
                hi_last   <= hi_cnt;
                seen_fall <= 1'b1;
            end
            bus_q <= {lcd_rs, lcd_db};
            if ({lcd_rs, lcd_db} != bus_q)
                bus_age <= '0;
            else if (bus_age != 16'hFFFF)
                bus_age <= bus_age + 1'b1;
        end
    end

    AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> (32'(bus_age) + 1 >= C_SU)); // R3
    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (32'(hi_cnt) >= C_HI)); // R4
    AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_e) && seen_fall) |-> (32'(lo_cnt) >= C_LO)); // R4
    AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_e) && seen_fall) |-> (32'(hi_last) + 32'(lo_cnt) >= C_CYC)); // R5
    AST_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> $stable({lcd_rs, lcd_db})); // R6
    AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable({lcd_rs, lcd_db}) && seen_fall) |-> (32'(lo_cnt) >= C_HLD)); // R6
    AST_READY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && seen_fall) |-> (!lcd_e && 32'(lo_cnt) >= C_HLD)); // R9

endmodule

// File: tb/sim_pbus_write_seq.sv
`timescale 1ns/1ps
module sim_pbus_write_seq;
    // Bench's own cycle figures for a 4 ns clock (ceil of ns / 4).
    localparam int SU   = (40 + 3) / 4;
    localparam int HI   = (220 + 3) / 4;
    localparam int LO   = (220 + 3) / 4;
    localparam int HLD  = (10 + 3) / 4;
    localparam int CYC  = (500 + 3) / 4;
    localparam int BEAT = CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_rs = 1'b0;
    logic [7:0] req_data = '0;
    logic       req_nibble = 1'b0;
    logic       req_ready, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_db;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    pbus_write_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_data(req_data), .req_nibble(req_nibble),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures intervals on falling clock edges and pops expected beats.
    logic       prev_e = 1'b0;
    logic [8:0] prev_bus = '0;
    int hi_len = 0, lo_len = 0, hi_last = 0, since_chg = 0, since_fall = 0;
    bit seen_fall = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (lcd_e && !prev_e) begin
                chk(since_chg >= SU, "R3 setup", since_chg, SU);
                if (seen_fall) begin
                    chk(lo_len >= LO, "R4 low width", lo_len, LO);
                    chk(hi_last + lo_len >= CYC, "R5 period", hi_last + lo_len, CYC);
                end
            end
            if (!lcd_e && prev_e) begin
                logic [8:0] e;
                pulses++;
                chk(hi_len >= HI, "R4 high width", hi_len, HI);
                chk(lcd_rw == 1'b0, "R2 rw low", lcd_rw, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected strobe", int'(prev_bus), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(prev_bus == e, "R7/R8 beat content", int'(prev_bus), int'(e));
                end
            end
            if ({lcd_rs, lcd_db} != prev_bus) begin
                chk(!lcd_e && !prev_e, "R6 stable while high", int'(lcd_e), 0);
                if (seen_fall)
                    chk(since_fall >= HLD, "R6 hold", since_fall, HLD);
                since_chg = 1;
            end else begin
                since_chg++;
            end
            if (lcd_e) begin
                hi_len = prev_e ? hi_len + 1 : 1;
            end else if (prev_e) begin
                hi_last = hi_len; lo_len = 1; since_fall = 1; seen_fall = 1;
            end else begin
                lo_len++; since_fall++;
            end
        end
        prev_e   = lcd_e;
        prev_bus = {lcd_rs, lcd_db};
    end

    // Driver: presents one request, queues its expected beats, times the busy window.
    task automatic send(input bit rs, input logic [7:0] d, input bit nib, input bit junk);
        int n;
        while (!req_ready) @(negedge clk);
        req_rs = rs; req_data = d; req_nibble = nib; req_valid = 1'b1;
        if (nib) begin
            exp_q.push_back({rs, d[7:4], 4'b0000});
            exp_q.push_back({rs, d[3:0], 4'b0000});
        end else begin
            exp_q.push_back({rs, d});
        end
        @(negedge clk);
        if (junk) begin
            req_rs = ~rs; req_data = ~d; req_nibble = ~nib;   // R9 ignored while busy
        end else begin
            req_valid = 1'b0;
        end
        n = 0;
        while (!req_ready) begin
            n++;
            if (n == 20) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == BEAT * (nib ? 2 : 1), "R9 busy length", n, BEAT * (nib ? 2 : 1));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(lcd_e == 1'b0, "R1 strobe", lcd_e, 0);
        chk(lcd_rw == 1'b0, "R1/R2 rw", lcd_rw, 0);
        chk({lcd_rs, lcd_db} == 9'd0, "R1 bus", {lcd_rs, lcd_db}, 0);
        send(1'b0, 8'h38, 1'b0, 1'b0);   // R7
        send(1'b1, 8'hA5, 1'b0, 1'b0);   // R7
        send(1'b1, 8'hFF, 1'b0, 1'b0);   // R7
        send(1'b0, 8'h3C, 1'b1, 1'b0);   // R8
        send(1'b1, 8'h96, 1'b1, 1'b1);   // R8, R9 junk while busy
        send(1'b0, 8'h00, 1'b0, 1'b1);   // R7, R9 junk while busy
        send(1'b1, 8'h5A, 1'b1, 1'b0);   // R8
        repeat (200) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all beats seen", exp_q.size(), 0);
        chk(pulses == 10, "R8 strobe count", pulses, 10);
        chk(lcd_e == 1'b0 && req_ready, "R9 idle after", int'(lcd_e), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule